// File: doc/BRIEF.md
# Banked Working-Register and Stack Data Memory

This block is the on-chip data memory controller of an 8-bit accumulator machine. It holds 128 bytes of scratch RAM. It exposes the eight working registers through a bank window, and it serves three further kinds of access. Direct accesses use a byte address. Indirect accesses use a pointer held in working register 0 or 1. Stack accesses use an 8-bit stack pointer. The instruction decoder drives one command per cycle, or a push or pop strobe, together with the two bank-select bits held in the status word. Results come back registered on `rd_data` with a one-cycle `rd_valid` pulse.

The control is a two-state machine. In `ST_IDLE` the block accepts a push, a pop or a command and completes it at the next clock edge. The single exception is an indirect command. Its transition `ACCEPT_IND` (`ST_IDLE` to `ST_IND`) latches the pointer byte read from the current bank. In `ST_IND` the block shows `busy`, performs the pointer access and takes transition `FINISH_IND` back to `ST_IDLE`. Every other accepted action is the self-loop `STAY_IDLE`.

The stack pointer is also reachable as special function address 0x81. It grows upward: a push increments the pointer and writes to the new top in the same edge, and a pop returns the current top and then decrements the pointer.

Top module: `iram_bank_ctrl`

## Requirements
- R1: On reset `sp` becomes 0x07 and `busy`, `rd_valid`, `range_err` and `stack_err` are 0. The state returns to `ST_IDLE` even if an indirect access was pending.
- R2: Working register n under `bank_sel` = b (bit 1 high-order, bit 0 low-order) lives at RAM address 8*b + n. Command codes: 0 = read register, 1 = write register, 2 = read direct, 3 = write direct, 4 = read indirect, 5 = write indirect, 6 and 7 = no operation.
- R3: A register write under one bank leaves the same register number of every other bank unchanged.
- R4: A direct address 0x00–0x7F reads or writes RAM. A read shows its byte on `rd_data` with `rd_valid` = 1 after the next rising edge.
- R5: Direct address 0x81 reads the stack pointer, and a write to it loads the stack pointer. Any other address from 0x80 to 0xFF reads as 0x00, and a write to it changes nothing.
- R6: A push sets `sp` to `sp`+1 (modulo 256) and writes `wdata` at the new `sp` in the same edge.
- R7: A pop returns the byte at the current `sp` on `rd_data` and sets `sp` to `sp`-1.
- R8: An indirect command with `ind_sel` = 0 or 1 takes its pointer from R0 or R1 of the bank selected at acceptance. `busy` is 1 for exactly the following cycle, and the result appears one edge later.
- R9: An indirect pointer, push target or pop source at or above 0x80 raises `range_err` for one cycle. A write is dropped, and a read returns 0x00 with `rd_valid` = 1.
- R10: A push and a pop in the same cycle raise `stack_err` for one cycle. `sp`, RAM and `rd_valid` are untouched, and any command in that cycle is dropped.
- R11: A push or pop strobe takes precedence over `cmd_valid`, and the command is dropped. While `busy` = 1 every new strobe and command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| reg_num | input | 3 | Working register number |
| dir_addr | input | 8 | Direct byte address |
| ind_sel | input | 1 | Indirect pointer choice: 0 = R0, 1 = R1 |
| wdata | input | 8 | Write or push data |
| bank_sel | input | 2 | Bank select from the status word |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | One-cycle read-result pulse |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Indirect access in progress |
| range_err | output | 1 | Out-of-range access pulse |
| stack_err | output | 1 | Push and pop collided |

## Verification
Two of this block's functions can fall in the same cycle. A stack strobe can coincide with a command, and a push can coincide with a pop. A further overlap is new stimulus arriving while an indirect access is still in its second cycle. The vector table provokes each case by driving the strobes and a conflicting direct write together. A following direct read then shows that the dropped write never reached RAM, and `sp` shows that the stack either moved once or stayed put.

// File: rtl/iram_pkg.sv
package iram_pkg;

    typedef enum logic [2:0] {
        OP_RD_REG = 3'd0,
        OP_WR_REG = 3'd1,
        OP_RD_DIR = 3'd2,
        OP_WR_DIR = 3'd3,
        OP_RD_IND = 3'd4,
        OP_WR_IND = 3'd5,
        OP_NOP6   = 3'd6,
        OP_NOP7   = 3'd7
    } iram_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_IND  = 1'b1
    } iram_state_e;

    typedef enum logic [1:0] {
        RD_RAM  = 2'd0,
        RD_SP   = 2'd1,
        RD_ZERO = 2'd2
    } iram_rdsrc_e;

endpackage

// File: rtl/iram_bank_map.sv
module iram_bank_map #(
    parameter int BANK_W = 2,
    parameter int REG_W  = 3,
    parameter int AW     = 7
) (
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [REG_W-1:0]  reg_num,
    input  logic              ind_sel,
    output logic [AW-1:0]     reg_addr,
    output logic [AW-1:0]     ptr_addr
);
    localparam int WIN_W = BANK_W + REG_W;

    logic [WIN_W-1:0] reg_win;
    logic [WIN_W-1:0] ptr_win;

    always_comb begin
        reg_win = {bank_sel, reg_num};
        ptr_win = {bank_sel, {(REG_W-1){1'b0}}, ind_sel};
    end

    assign reg_addr = AW'(reg_win);
    assign ptr_addr = AW'(ptr_win);

endmodule

// File: rtl/iram_store.sv
module iram_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr #(
    parameter int          DW        = 8,
    parameter logic [7:0]  RESET_VAL = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] sp_up
);
    assign sp_up = sp_q + DW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= DW'(RESET_VAL);
        end else if (load) begin
            sp_q <= load_val;
        end else if (inc) begin
            sp_q <= sp_up;
        end else if (dec) begin
            sp_q <= sp_q - DW'(1);
        end
    end

endmodule

// File: rtl/iram_bank_ctrl.sv
module iram_bank_ctrl
    import iram_pkg::*;
#(
    parameter int         DW            = 8,
    parameter int         RAM_DEPTH     = 128,
    parameter int         NUM_BANKS     = 4,
    parameter int         REGS_PER_BANK = 8,
    parameter logic [7:0] SP_RESET      = 8'h07,
    parameter logic [7:0] SP_SFR_ADDR   = 8'h81,
    localparam int        AW            = $clog2(RAM_DEPTH),
    localparam int        BANK_W        = $clog2(NUM_BANKS),
    localparam int        REG_W         = $clog2(REGS_PER_BANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [DW-1:0]     dir_addr,
    input  logic              ind_sel,
    input  logic [DW-1:0]     wdata,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic [DW-1:0]     sp,
    output logic              busy,
    output logic              range_err,
    output logic              stack_err
);
    localparam logic [DW:0] RAM_LIMIT = (DW+1)'(RAM_DEPTH);

    function automatic logic in_ram(input logic [DW-1:0] a);
        return {1'b0, a} < RAM_LIMIT;
    endfunction

    iram_state_e   state_q, state_d;

    logic [AW-1:0] reg_addr, ptr_addr;
    logic [AW-1:0] ra_addr;
    logic [DW-1:0] ra_data, pb_data;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] sp_q, sp_up;
    logic          sp_inc, sp_dec, sp_load;

    logic          do_read;
    iram_rdsrc_e   rd_src;
    logic [DW-1:0] rd_value;
    logic          set_range, set_stack;
    logic          ptr_cap;

    logic [DW-1:0] ptr_q;
    logic          ind_wr_q;
    logic [DW-1:0] ind_wd_q;

    iram_bank_map #(
        .BANK_W (BANK_W),
        .REG_W  (REG_W),
        .AW     (AW)
    ) u_map (
        .bank_sel (bank_sel),
        .reg_num  (reg_num),
        .ind_sel  (ind_sel),
        .reg_addr (reg_addr),
        .ptr_addr (ptr_addr)
    );

    iram_store #(
        .DW    (DW),
        .DEPTH (RAM_DEPTH),
        .AW    (AW)
    ) u_store (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (ra_addr),
        .rdata_a (ra_data),
        .raddr_b (ptr_addr),
        .rdata_b (pb_data)
    );

    iram_stack_ptr #(
        .DW        (DW),
        .RESET_VAL (SP_RESET)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (sp_inc),
        .dec      (sp_dec),
        .load     (sp_load),
        .load_val (wdata),
        .sp_q     (sp_q),
        .sp_up    (sp_up)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-cycle actions
    always_comb begin
        state_d   = state_q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = wdata;
        ra_addr   = '0;
        do_read   = 1'b0;
        rd_src    = RD_RAM;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        sp_load   = 1'b0;
        set_range = 1'b0;
        set_stack = 1'b0;
        ptr_cap   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (push && pop) begin
                    set_stack = 1'b1;
                end else if (push) begin
                    sp_inc = 1'b1;
                    if (in_ram(sp_up)) begin
                        mem_we    = 1'b1;
                        mem_waddr = sp_up[AW-1:0];
                    end else begin
                        set_range = 1'b1;
                    end
                end else if (pop) begin
                    sp_dec  = 1'b1;
                    do_read = 1'b1;
                    if (in_ram(sp_q)) begin
                        ra_addr = sp_q[AW-1:0];
                    end else begin
                        rd_src    = RD_ZERO;
                        set_range = 1'b1;
                    end
                end else if (cmd_valid) begin
                    unique case (iram_op_e'(cmd_op))
                        OP_RD_REG: begin
                            do_read = 1'b1;
                            ra_addr = reg_addr;
                        end
                        OP_WR_REG: begin
                            mem_we    = 1'b1;
                            mem_waddr = reg_addr;
                        end
                        OP_RD_DIR: begin
                            do_read = 1'b1;
                            if (in_ram(dir_addr)) begin
                                ra_addr = dir_addr[AW-1:0];
                            end else if (dir_addr == SP_SFR_ADDR) begin
                                rd_src = RD_SP;
                            end else begin
                                rd_src = RD_ZERO;
                            end
                        end
                        OP_WR_DIR: begin
                            if (in_ram(dir_addr)) begin
                                mem_we    = 1'b1;
                                mem_waddr = dir_addr[AW-1:0];
                            end else if (dir_addr == SP_SFR_ADDR) begin
                                sp_load = 1'b1;
                            end
                        end
                        OP_RD_IND, OP_WR_IND: begin
                            ptr_cap = 1'b1;
                            state_d = ST_IND;
                        end
                        default: ;
                    endcase
                end
            end
            ST_IND: begin
                state_d = ST_IDLE;
                if (in_ram(ptr_q)) begin
                    if (ind_wr_q) begin
                        mem_we    = 1'b1;
                        mem_waddr = ptr_q[AW-1:0];
                        mem_wdata = ind_wd_q;
                    end else begin
                        do_read = 1'b1;
                        ra_addr = ptr_q[AW-1:0];
                    end
                end else begin
                    set_range = 1'b1;
                    if (!ind_wr_q) begin
                        do_read = 1'b1;
                        rd_src  = RD_ZERO;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (rd_src)
            RD_SP:   rd_value = sp_q;
            RD_ZERO: rd_value = '0;
            default: rd_value = ra_data;
        endcase
    end

    // Registered outputs and indirect capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            range_err <= 1'b0;
            stack_err <= 1'b0;
            ptr_q     <= '0;
            ind_wr_q  <= 1'b0;
            ind_wd_q  <= '0;
        end else begin
            rd_valid  <= do_read;
            range_err <= set_range;
            stack_err <= set_stack;
            if (do_read) begin
                rd_data <= rd_value;
            end
            if (ptr_cap) begin
                ptr_q    <= pb_data;
                ind_wr_q <= (cmd_op == 3'(OP_WR_IND));
                ind_wd_q <= wdata;
            end
        end
    end

    assign sp   = sp_q;
    assign busy = (state_q == ST_IND);

endmodule

// File: rtl/iram_bank_ctrl_chk.sv
module iram_bank_ctrl_chk #(
    parameter logic [7:0] SP_RESET = 8'h07
) (
    input logic       clk,
    input logic       rst_n,
    input logic       push,
    input logic       pop,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [7:0] sp,
    input logic       busy,
    input logic       rd_valid,
    input logic       range_err,
    input logic       stack_err
);
    AST_RESET_SP: assert property (@(posedge clk) !rst_n |=> (sp == SP_RESET && !busy)); // R1

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push && !pop) |=> (sp == $past(sp) + 8'd1)); // R6

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pop && !push) |=> (sp == $past(sp) - 8'd1 && rd_valid)); // R7

    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push && pop) |=> (stack_err && $stable(sp) && !rd_valid)); // R10

    AST_IND_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !push && !pop && cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5)) |=> busy); // R8

    AST_IND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R8

    AST_BUSY_HOLDS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sp)); // R11

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |-> !range_err); // R10

endmodule

bind iram_bank_ctrl iram_bank_ctrl_chk #(
    .SP_RESET (SP_RESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .sp        (sp),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .range_err (range_err),
    .stack_err (stack_err)
);

// File: tb/iram_bank_ctrl_bench.sv
`timescale 1ns/1ps
module iram_bank_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push = 1'b0, pop = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd6;
    logic [2:0] reg_num = '0;
    logic [7:0] dir_addr = '0;
    logic       ind_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] bank_sel = '0;
    logic [7:0] rd_data, sp;
    logic       rd_valid, busy, range_err, stack_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    iram_bank_ctrl u_iram_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .reg_num   (reg_num),
        .dir_addr  (dir_addr),
        .ind_sel   (ind_sel),
        .wdata     (wdata),
        .bank_sel  (bank_sel),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .sp        (sp),
        .busy      (busy),
        .range_err (range_err),
        .stack_err (stack_err)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       pu, po, cv;
        logic [2:0] op;
        logic [2:0] rn;
        logic [7:0] da;
        logic       is;
        logic [7:0] wd;
        logic [1:0] bk;
        logic       ev;
        logic [7:0] ed;
        logic [7:0] esp;
        logic       ere, ese, eb;
    } row_t;

    localparam int NROWS = 41;
    localparam row_t ROWS [NROWS] = '{
        '{4'd2, 1'b0,1'b0,1'b1, 3'd1,3'd3,8'h00,1'b0,8'h11,2'd0, 1'b0,8'h00,8'h07, 1'b0,1'b0,1'b0}, // R2 wr R3 bank0
        '{4'd2, 1'b0,1'b0,1'b1, 3'd1,3'd3,8'h00,1'b0,8'h22,2'd1, 1'b0,8'h00,8'h07, 1'b0,1'b0,1'b0}, // R2 wr R3 bank1
        '{4'd3, 1'b0,1'b0,1'b1, 3'd0,3'd3,8'h00,1'b0,8'h00,2'd0, 1'b1,8'h11,8'h07, 1'b0,1'b0,1'b0}, // R3 bank0 intact
        '{4'd2, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h0B,1'b0,8'h00,2'd0, 1'b1,8'h22,8'h07, 1'b0,1'b0,1'b0}, // R2 0x0B
        '{4'd2, 1'b0,1'b0,1'b1, 3'd1,3'd7,8'h00,1'b0,8'h33,2'd3, 1'b0,8'h00,8'h07, 1'b0,1'b0,1'b0}, // R2 bank3 R7
        '{4'd2, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h1F,1'b0,8'h00,2'd0, 1'b1,8'h33,8'h07, 1'b0,1'b0,1'b0}, // R2 0x1F
        '{4'd2, 1'b0,1'b0,1'b1, 3'd1,3'd0,8'h00,1'b0,8'h44,2'd2, 1'b0,8'h00,8'h07, 1'b0,1'b0,1'b0}, // R2 bank2 R0
        '{4'd2, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h10,1'b0,8'h00,2'd0, 1'b1,8'h44,8'h07, 1'b0,1'b0,1'b0}, // R2 0x10
        '{4'd4, 1'b0,1'b0,1'b1, 3'd3,3'd0,8'h40,1'b0,8'h55,2'd0, 1'b0,8'h00,8'h07, 1'b0,1'b0,1'b0}, // R4 wr 0x40
        '{4'd4, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h40,1'b0,8'h00,2'd0, 1'b1,8'h55,8'h07, 1'b0,1'b0,1'b0}, // R4 rd 0x40
        '{4'd5, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h81,1'b0,8'h00,2'd0, 1'b1,8'h07,8'h07, 1'b0,1'b0,1'b0}, // R5 rd sp
        '{4'd5, 1'b0,1'b0,1'b1, 3'd3,3'd0,8'h90,1'b0,8'hAA,2'd0, 1'b0,8'h00,8'h07, 1'b0,1'b0,1'b0}, // R5 wr 0x90
        '{4'd5, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h90,1'b0,8'h00,2'd0, 1'b1,8'h00,8'h07, 1'b0,1'b0,1'b0}, // R5 rd 0x90
        '{4'd6, 1'b1,1'b0,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h66,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b0}, // R6 push
        '{4'd6, 1'b1,1'b0,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h77,2'd0, 1'b0,8'h00,8'h09, 1'b0,1'b0,1'b0}, // R6 push
        '{4'd6, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h09,1'b0,8'h00,2'd0, 1'b1,8'h77,8'h09, 1'b0,1'b0,1'b0}, // R6 top
        '{4'd7, 1'b0,1'b1,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b1,8'h77,8'h08, 1'b0,1'b0,1'b0}, // R7 pop
        '{4'd7, 1'b0,1'b1,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b1,8'h66,8'h07, 1'b0,1'b0,1'b0}, // R7 pop
        '{4'd10,1'b1,1'b1,1'b1, 3'd2,3'd0,8'h40,1'b0,8'h99,2'd0, 1'b0,8'h00,8'h07, 1'b0,1'b1,1'b0}, // R10 collide
        '{4'd10,1'b0,1'b0,1'b1, 3'd2,3'd0,8'h08,1'b0,8'h00,2'd0, 1'b1,8'h66,8'h07, 1'b0,1'b0,1'b0}, // R10 ram kept
        '{4'd11,1'b1,1'b0,1'b1, 3'd3,3'd0,8'h40,1'b0,8'h12,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b0}, // R11 push wins
        '{4'd11,1'b0,1'b0,1'b1, 3'd2,3'd0,8'h40,1'b0,8'h00,2'd0, 1'b1,8'h55,8'h08, 1'b0,1'b0,1'b0}, // R11 cmd dropped
        '{4'd8, 1'b0,1'b0,1'b1, 3'd1,3'd0,8'h00,1'b0,8'h40,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b0}, // R8 R0=0x40
        '{4'd8, 1'b0,1'b0,1'b1, 3'd4,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b1}, // R8 accept
        '{4'd8, 1'b0,1'b0,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b1,8'h55,8'h08, 1'b0,1'b0,1'b0}, // R8 result
        '{4'd9, 1'b0,1'b0,1'b1, 3'd1,3'd1,8'h00,1'b0,8'h90,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b0}, // R9 R1=0x90
        '{4'd9, 1'b0,1'b0,1'b1, 3'd5,3'd0,8'h00,1'b1,8'h5A,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b1}, // R9 wr ind
        '{4'd9, 1'b0,1'b0,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b0,8'h00,8'h08, 1'b1,1'b0,1'b0}, // R9 flagged
        '{4'd9, 1'b0,1'b0,1'b1, 3'd4,3'd0,8'h00,1'b1,8'h00,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b1}, // R9 rd ind
        '{4'd9, 1'b0,1'b0,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b1,8'h00,8'h08, 1'b1,1'b0,1'b0}, // R9 zero
        '{4'd9, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h40,1'b0,8'h00,2'd0, 1'b1,8'h55,8'h08, 1'b0,1'b0,1'b0}, // R9 ram kept
        '{4'd11,1'b0,1'b0,1'b1, 3'd4,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b1}, // R11 busy next
        '{4'd11,1'b1,1'b0,1'b1, 3'd3,3'd0,8'h40,1'b0,8'hEE,2'd0, 1'b1,8'h55,8'h08, 1'b0,1'b0,1'b0}, // R11 ignored
        '{4'd11,1'b0,1'b0,1'b1, 3'd2,3'd0,8'h40,1'b0,8'h00,2'd0, 1'b1,8'h55,8'h08, 1'b0,1'b0,1'b0}, // R11 ram kept
        '{4'd8, 1'b0,1'b0,1'b1, 3'd1,3'd0,8'h00,1'b0,8'h1F,2'd2, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b0}, // R8 bank2 R0
        '{4'd8, 1'b0,1'b0,1'b1, 3'd4,3'd0,8'h00,1'b0,8'h00,2'd2, 1'b0,8'h00,8'h08, 1'b0,1'b0,1'b1}, // R8 accept
        '{4'd8, 1'b0,1'b0,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b1,8'h33,8'h08, 1'b0,1'b0,1'b0}, // R8 result
        '{4'd5, 1'b0,1'b0,1'b1, 3'd3,3'd0,8'h81,1'b0,8'h7F,2'd0, 1'b0,8'h00,8'h7F, 1'b0,1'b0,1'b0}, // R5 load sp
        '{4'd9, 1'b1,1'b0,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h01,2'd0, 1'b0,8'h00,8'h80, 1'b1,1'b0,1'b0}, // R9 push 0x80
        '{4'd9, 1'b0,1'b1,1'b0, 3'd6,3'd0,8'h00,1'b0,8'h00,2'd0, 1'b1,8'h00,8'h7F, 1'b1,1'b0,1'b0}, // R9 pop 0x80
        '{4'd5, 1'b0,1'b0,1'b1, 3'd2,3'd0,8'h81,1'b0,8'h00,2'd0, 1'b1,8'h7F,8'h7F, 1'b0,1'b0,1'b0}  // R5 rd sp
    };

    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic pu, input logic po, input logic cv, input logic [2:0] op,
                         input logic [2:0] rn, input logic [7:0] da, input logic is,
                         input logic [7:0] wd, input logic [1:0] bk);
        push = pu; pop = po; cmd_valid = cv; cmd_op = op;
        reg_num = rn; dir_addr = da; ind_sel = is; wdata = wd; bank_sel = bk;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(1, "sp at reset", sp, 8'h07);
        chk(1, "busy at reset", {7'd0, busy}, 8'h00);
        chk(1, "rd_valid at reset", {7'd0, rd_valid}, 8'h00);
        chk(1, "errors at reset", {6'd0, range_err, stack_err}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            drive(ROWS[i].pu, ROWS[i].po, ROWS[i].cv, ROWS[i].op, ROWS[i].rn,
                  ROWS[i].da, ROWS[i].is, ROWS[i].wd, ROWS[i].bk);
            tick();
            chk(int'(ROWS[i].req), $sformatf("row %0d rd_valid", i), {7'd0, rd_valid}, {7'd0, ROWS[i].ev});
            if (ROWS[i].ev) begin
                chk(int'(ROWS[i].req), $sformatf("row %0d rd_data", i), rd_data, ROWS[i].ed);
            end
            chk(int'(ROWS[i].req), $sformatf("row %0d sp", i), sp, ROWS[i].esp);
            chk(int'(ROWS[i].req), $sformatf("row %0d range_err", i), {7'd0, range_err}, {7'd0, ROWS[i].ere});
            chk(int'(ROWS[i].req), $sformatf("row %0d stack_err", i), {7'd0, stack_err}, {7'd0, ROWS[i].ese});
            chk(int'(ROWS[i].req), $sformatf("row %0d busy", i), {7'd0, busy}, {7'd0, ROWS[i].eb});
        end

        // R6: pointer wraps from 0xFF to 0x00 and the push lands at 0x00
        drive(0, 0, 1, 3'd3, 3'd0, 8'h81, 0, 8'hFF, 2'd0);
        tick();
        drive(1, 0, 0, 3'd6, 3'd0, 8'h00, 0, 8'h3C, 2'd0);
        tick();
        chk(6, "wrap sp", sp, 8'h00);
        chk(6, "wrap range_err", {7'd0, range_err}, 8'h00);
        drive(0, 0, 1, 3'd2, 3'd0, 8'h00, 0, 8'h00, 2'd0);
        tick();
        chk(6, "wrap data at 0x00", rd_data, 8'h3C);

        // R1: reset while an indirect access is pending
        drive(0, 0, 1, 3'd4, 3'd0, 8'h00, 0, 8'h00, 2'd0);
        tick();
        chk(1, "busy before reset", {7'd0, busy}, 8'h01);
        drive(0, 0, 0, 3'd6, 3'd0, 8'h00, 0, 8'h00, 2'd0);
        rst_n = 1'b0;
        #1;
        chk(1, "busy in reset", {7'd0, busy}, 8'h00);
        chk(1, "sp in reset", sp, 8'h07);
        chk(1, "rd_valid in reset", {7'd0, rd_valid}, 8'h00);
        tick();
        rst_n = 1'b1;
        tick();
        chk(1, "busy after reset", {7'd0, busy}, 8'h00);
        chk(1, "sp after reset", sp, 8'h07);

        finish_run();
    end

endmodule